// File: doc/BRIEF.md
# Device Error Classifier and Signaler

This block sits behind the error detectors of a serial-link endpoint or port. Each cycle it can take one detected-error event: a status vector naming the error, a flag saying whether the error belongs to the correctable or the uncorrectable class, a flag allowing a non-fatal error to be downgraded to an advisory one, and the 16-bit requester identity that goes into any resulting message. The block filters the vector against the bits it supports and decides the severity from a programmable severity register or a built-in default table. It then updates the sticky device-level and per-error status registers, applies the correctable and uncorrectable masks and the reporting enables, and decides whether an error message leaves the block and with which severity.

When an uncorrectable error must be recorded, the block pulses a request to a separate header-logging unit. If that unit answers that its storage has overflowed, the block raises a header-log-overflow correctable error of its own. That error runs through the same classification path in a later cycle. New events are held off while the logging answer and any follow-up error are pending. All configuration registers arrive as plain input levels, and the status registers are cleared through per-bit clear inputs.

Top module: `err_signal_unit`

## Requirements
- R1: The event vector is first ANDed with the supported-bit set of its class (correctable supported = 0x0000F1C1, uncorrectable supported = 0x03FFF030). If zero bits or more than one bit then remain, the event changes no status register, produces no message and no log request.
- R2: An uncorrectable error is fatal when `cfg_sev_use_reg` is 1 and its bit is set in `cfg_unc_sev`. When `cfg_sev_use_reg` is 0, it is fatal when its bit is in the default fatal set 0x00462030, which covers bits 4, 5, 13, 17, 18 and 22. Otherwise it is non-fatal.
- R3: A valid correctable event sets `dev_status[0]` and its own bit in `cor_status`. It produces a correctable message only when its bit is clear in `cfg_cor_mask` and `cfg_cor_rep_en` is 1.
- R4: An uncorrectable event whose bit is set in `cfg_unc_mask` still sets its `unc_status` bit and its severity bit in `dev_status`. It raises neither a log request nor a message.
- R5: An unmasked uncorrectable event sets its `unc_status` bit. It sets `dev_status[2]` if fatal or `dev_status[1]` if non-fatal. One cycle after acceptance it pulses `log_req` with `log_status` equal to the single filtered bit.
- R6: A non-fatal uncorrectable event with `evt_adv_ok` set is handled as an advisory error. It sets `unc_status` for its bit, `cor_status` bit 13 and `dev_status[0]`. It requests logging only when its bit is clear in `cfg_unc_mask`. It produces a correctable message when bit 13 of `cfg_cor_mask` is clear and `cfg_cor_rep_en` is 1. An event that is fatal ignores `evt_adv_ok`.
- R7: The unsupported-request error (uncorrectable bit 20) also sets `dev_status[3]`. On the uncorrectable path its message is dropped when both `cfg_ur_rep_en` and `cfg_serr_en` are 0. On the advisory path, `cfg_ur_rep_en` at 0 alone drops it.
- R8: A fatal message needs `cfg_serr_en` or `cfg_fat_rep_en`. A non-fatal message needs `cfg_serr_en` or `cfg_nf_rep_en`.
- R9: If `log_ovf` is high while `log_req` is high, the block processes a correctable error on bit 15 two cycles after that `log_req` cycle, using the source ID of the logged event. This error follows R3.
- R10: `msg_valid` is a one-cycle pulse in the cycle after the event is accepted. It carries `msg_sev` (01 correctable, 10 non-fatal, 11 fatal) and `msg_src`. `msg_sev` is 00 whenever `msg_valid` is 0.
- R11: After reset `evt_ready` is 1 and all status outputs are 0. `evt_ready` is 0 while `log_req` is high and during the cycle in which an overflow follow-up is pending.
- R12: A 1 on a bit of `clr_cor`, `clr_unc` or `clr_dev` clears that status bit at the next edge. A set from an event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Event may be accepted this cycle |
| evt_status | input | STAT_W | Error status vector of the event |
| evt_is_cor | input | 1 | 1 = correctable class, 0 = uncorrectable |
| evt_adv_ok | input | 1 | Non-fatal event may be downgraded to advisory |
| evt_src | input | SRC_W | Requester identity for the message |
| cfg_cor_mask | input | STAT_W | Correctable mask register |
| cfg_unc_mask | input | STAT_W | Uncorrectable mask register |
| cfg_unc_sev | input | STAT_W | Uncorrectable severity register (1 = fatal) |
| cfg_sev_use_reg | input | 1 | Severity register present and used |
| cfg_serr_en | input | 1 | System-error enable |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Non-fatal reporting enable |
| cfg_fat_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| clr_cor | input | STAT_W | Per-bit clear of cor_status |
| clr_unc | input | STAT_W | Per-bit clear of unc_status |
| clr_dev | input | 4 | Per-bit clear of dev_status |
| log_req | output | 1 | Header-log request pulse |
| log_status | output | STAT_W | Single error bit to be logged |
| log_src | output | SRC_W | Source identity of the logged error |
| log_ovf | input | 1 | Logging unit overflowed, valid while log_req is high |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_src | output | SRC_W | Message source identity |
| dev_status | output | 4 | [0] correctable, [1] non-fatal, [2] fatal, [3] unsupported request detected |
| cor_status | output | STAT_W | Sticky correctable error status |
| unc_status | output | STAT_W | Sticky uncorrectable error status |

## Verification
Single-bit events are sent from both classes, along with vectors with zero bits, two bits, or extra unsupported bits that filtering removes. This separates the rejection path from the filtering path. The same error bit is replayed with the severity register on and off, with masks set in each register, and with every reporting enable toggled. That pins down which gate blocks a message and which status bits are still set. The unsupported-request error is driven on both the uncorrectable and the advisory path, and a forced logging overflow confirms the delayed follow-up error and the hold on new events. A behavioural reference model is compared with every output on every clock, in addition to the directed checks.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;
  typedef enum logic [1:0] {
    SEV_NONE     = 2'b00,
    SEV_COR      = 2'b01,
    SEV_NONFATAL = 2'b10,
    SEV_FATAL    = 2'b11
  } err_sev_e;

  localparam int DEV_W   = 4;
  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;
endpackage

// File: rtl/err_sticky_bits.sv
module err_sticky_bits #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)           bit_q <= 1'b0;
      else if (set_v[i]) bit_q <= 1'b1;
      else if (clr_v[i]) bit_q <= 1'b0;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/err_classify.sv
module err_classify
  import err_sig_pkg::*;
#(
  parameter int              STAT_W        = 32,
  parameter logic [STAT_W-1:0] COR_SUPPORTED = 'h0000F1C1,
  parameter logic [STAT_W-1:0] UNC_SUPPORTED = 'h03FFF030,
  parameter logic [STAT_W-1:0] UNC_DEF_FATAL = 'h00462030,
  parameter int              UR_POS        = 20,
  parameter int              ADV_POS       = 13
) (
  input  logic [STAT_W-1:0] ev_status,
  input  logic              ev_cor,
  input  logic              ev_adv,
  input  logic [STAT_W-1:0] cfg_cor_mask,
  input  logic [STAT_W-1:0] cfg_unc_mask,
  input  logic [STAT_W-1:0] cfg_unc_sev,
  input  logic              cfg_sev_use_reg,
  input  logic              cfg_serr_en,
  input  logic              cfg_cor_rep_en,
  input  logic              cfg_nf_rep_en,
  input  logic              cfg_fat_rep_en,
  input  logic              cfg_ur_rep_en,
  output logic [STAT_W-1:0] set_cor,
  output logic [STAT_W-1:0] set_unc,
  output logic [DEV_W-1:0]  set_dev,
  output logic              fire_msg,
  output err_sev_e          sev,
  output logic              fire_log,
  output logic [STAT_W-1:0] log_vec
);
  localparam logic [STAT_W-1:0] ONE_VEC = {{(STAT_W-1){1'b0}}, 1'b1};
  localparam logic [STAT_W-1:0] UR_VEC  = ONE_VEC << UR_POS;
  localparam logic [STAT_W-1:0] ADV_VEC = ONE_VEC << ADV_POS;

  logic [STAT_W-1:0] sv;
  logic              single;
  logic              is_ur;
  logic              fatal;
  logic              unc_masked;

  always_comb begin
    sv         = ev_cor ? (ev_status & COR_SUPPORTED) : (ev_status & UNC_SUPPORTED);
    single     = (sv != '0) && ((sv & (sv - ONE_VEC)) == '0);
    is_ur      = !ev_cor && (sv == UR_VEC);
    fatal      = cfg_sev_use_reg ? |(sv & cfg_unc_sev) : |(sv & UNC_DEF_FATAL);
    unc_masked = |(sv & cfg_unc_mask);
    log_vec    = sv;
    set_cor    = '0;
    set_unc    = '0;
    set_dev    = '0;
    fire_msg   = 1'b0;
    fire_log   = 1'b0;
    sev        = SEV_NONE;
    if (single) begin
      if (is_ur) set_dev[DEV_UR] = 1'b1;
      if (ev_cor) begin
        set_dev[DEV_COR] = 1'b1;
        set_cor          = sv;
        if (!(|(sv & cfg_cor_mask)) && cfg_cor_rep_en) begin
          fire_msg = 1'b1;
          sev      = SEV_COR;
        end
      end else if (!fatal && ev_adv) begin
        set_dev[DEV_COR] = 1'b1;
        set_cor          = ADV_VEC;
        set_unc          = sv;
        fire_log         = !unc_masked;
        if (!(|(ADV_VEC & cfg_cor_mask)) && !(is_ur && !cfg_ur_rep_en) && cfg_cor_rep_en) begin
          fire_msg = 1'b1;
          sev      = SEV_COR;
        end
      end else begin
        if (fatal) set_dev[DEV_FAT] = 1'b1;
        else       set_dev[DEV_NF]  = 1'b1;
        set_unc = sv;
        if (!unc_masked) begin
          fire_log = 1'b1;
          if (!(is_ur && !cfg_ur_rep_en && !cfg_serr_en)) begin
            if (fatal && (cfg_serr_en || cfg_fat_rep_en)) begin
              fire_msg = 1'b1;
              sev      = SEV_FATAL;
            end else if (!fatal && (cfg_serr_en || cfg_nf_rep_en)) begin
              fire_msg = 1'b1;
              sev      = SEV_NONFATAL;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/err_followup.sv
module err_followup #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             log_busy,
  input  logic             log_ovf,
  input  logic [SRC_W-1:0] log_src,
  output logic             pend,
  output logic [SRC_W-1:0] pend_src,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_src <= '0;
    end else begin
      pend <= log_busy && log_ovf;
      if (log_busy && log_ovf) pend_src <= log_src;
    end
  end

  assign ready = !log_busy && !pend;
endmodule

// File: rtl/err_signal_unit.sv
module err_signal_unit
  import err_sig_pkg::*;
#(
  parameter int                STAT_W        = 32,
  parameter int                SRC_W         = 16,
  parameter logic [STAT_W-1:0] COR_SUPPORTED = 'h0000F1C1,
  parameter logic [STAT_W-1:0] UNC_SUPPORTED = 'h03FFF030,
  parameter logic [STAT_W-1:0] UNC_DEF_FATAL = 'h00462030,
  parameter int                UR_POS        = 20,
  parameter int                ADV_POS       = 13,
  parameter int                HLO_POS       = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [STAT_W-1:0] evt_status,
  input  logic              evt_is_cor,
  input  logic              evt_adv_ok,
  input  logic [SRC_W-1:0]  evt_src,
  input  logic [STAT_W-1:0] cfg_cor_mask,
  input  logic [STAT_W-1:0] cfg_unc_mask,
  input  logic [STAT_W-1:0] cfg_unc_sev,
  input  logic              cfg_sev_use_reg,
  input  logic              cfg_serr_en,
  input  logic              cfg_cor_rep_en,
  input  logic              cfg_nf_rep_en,
  input  logic              cfg_fat_rep_en,
  input  logic              cfg_ur_rep_en,
  input  logic [STAT_W-1:0] clr_cor,
  input  logic [STAT_W-1:0] clr_unc,
  input  logic [3:0]        clr_dev,
  output logic              log_req,
  output logic [STAT_W-1:0] log_status,
  output logic [SRC_W-1:0]  log_src,
  input  logic              log_ovf,
  output logic              msg_valid,
  output logic [1:0]        msg_sev,
  output logic [SRC_W-1:0]  msg_src,
  output logic [3:0]        dev_status,
  output logic [STAT_W-1:0] cor_status,
  output logic [STAT_W-1:0] unc_status
);
  localparam logic [STAT_W-1:0] HLO_VEC = {{(STAT_W-1){1'b0}}, 1'b1} << HLO_POS;

  logic              pend;
  logic [SRC_W-1:0]  pend_src;
  logic              ev_go;
  logic [STAT_W-1:0] ev_status;
  logic              ev_cor;
  logic              ev_adv;
  logic [SRC_W-1:0]  ev_src;

  logic [STAT_W-1:0] c_set_cor, c_set_unc, c_log_vec;
  logic [DEV_W-1:0]  c_set_dev;
  logic              c_msg, c_log;
  err_sev_e          c_sev;

  err_followup #(.SRC_W(SRC_W)) u_follow (
    .clk      (clk),
    .rst      (rst),
    .log_busy (log_req),
    .log_ovf  (log_ovf),
    .log_src  (log_src),
    .pend     (pend),
    .pend_src (pend_src),
    .ready    (evt_ready)
  );

  // A pending overflow follow-up takes the slot ahead of new input.
  always_comb begin
    ev_go     = pend || (evt_valid && evt_ready);
    ev_status = pend ? HLO_VEC : evt_status;
    ev_cor    = pend ? 1'b1    : evt_is_cor;
    ev_adv    = pend ? 1'b0    : evt_adv_ok;
    ev_src    = pend ? pend_src : evt_src;
  end

  err_classify #(
    .STAT_W        (STAT_W),
    .COR_SUPPORTED (COR_SUPPORTED),
    .UNC_SUPPORTED (UNC_SUPPORTED),
    .UNC_DEF_FATAL (UNC_DEF_FATAL),
    .UR_POS        (UR_POS),
    .ADV_POS       (ADV_POS)
  ) u_class (
    .ev_status       (ev_status),
    .ev_cor          (ev_cor),
    .ev_adv          (ev_adv),
    .cfg_cor_mask    (cfg_cor_mask),
    .cfg_unc_mask    (cfg_unc_mask),
    .cfg_unc_sev     (cfg_unc_sev),
    .cfg_sev_use_reg (cfg_sev_use_reg),
    .cfg_serr_en     (cfg_serr_en),
    .cfg_cor_rep_en  (cfg_cor_rep_en),
    .cfg_nf_rep_en   (cfg_nf_rep_en),
    .cfg_fat_rep_en  (cfg_fat_rep_en),
    .cfg_ur_rep_en   (cfg_ur_rep_en),
    .set_cor         (c_set_cor),
    .set_unc         (c_set_unc),
    .set_dev         (c_set_dev),
    .fire_msg        (c_msg),
    .sev             (c_sev),
    .fire_log        (c_log),
    .log_vec         (c_log_vec)
  );

  err_sticky_bits #(.W(STAT_W)) u_cor_sts (
    .clk (clk), .rst (rst),
    .set_v (ev_go ? c_set_cor : '0), .clr_v (clr_cor), .q (cor_status)
  );

  err_sticky_bits #(.W(STAT_W)) u_unc_sts (
    .clk (clk), .rst (rst),
    .set_v (ev_go ? c_set_unc : '0), .clr_v (clr_unc), .q (unc_status)
  );

  err_sticky_bits #(.W(DEV_W)) u_dev_sts (
    .clk (clk), .rst (rst),
    .set_v (ev_go ? c_set_dev : '0), .clr_v (clr_dev), .q (dev_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_sev    <= SEV_NONE;
      msg_src    <= '0;
      log_req    <= 1'b0;
      log_status <= '0;
      log_src    <= '0;
    end else begin
      msg_valid <= ev_go && c_msg;
      msg_sev   <= (ev_go && c_msg) ? c_sev : SEV_NONE;
      if (ev_go && c_msg) msg_src <= ev_src;
      log_req <= ev_go && c_log;
      if (ev_go && c_log) begin
        log_status <= c_log_vec;
        log_src    <= ev_src;
      end
    end
  end
endmodule

// File: rtl/err_signal_checker.sv
module err_signal_checker #(
  parameter int STAT_W  = 32,
  parameter int HLO_POS = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_ready,
  input logic              log_req,
  input logic [STAT_W-1:0] log_status,
  input logic              log_ovf,
  input logic              msg_valid,
  input logic [1:0]        msg_sev,
  input logic [3:0]        dev_status,
  input logic [STAT_W-1:0] cor_status,
  input logic [STAT_W-1:0] clr_cor
);
  p_log_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    log_req |-> $onehot(log_status));

  p_msg_code_r10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_sev != 2'b00));

  p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
    !msg_valid |-> (msg_sev == 2'b00));

  p_cor_msg_dev_r3: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'b01) |-> dev_status[0]);

  p_fatal_msg_dev_r8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'b11) |-> dev_status[2]);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    log_req |-> !evt_ready);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (log_req && log_ovf) |=> !evt_ready);

  p_ovf_status_r9: assert property (@(posedge clk) disable iff (rst)
    (log_req && log_ovf) |=> ##1 cor_status[HLO_POS]);

  p_sticky_cor_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(clr_cor) == '0)) |->
      ((cor_status & $past(cor_status)) == $past(cor_status)));
endmodule

bind err_signal_unit err_signal_checker #(.STAT_W(STAT_W), .HLO_POS(HLO_POS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_ready  (evt_ready),
  .log_req    (log_req),
  .log_status (log_status),
  .log_ovf    (log_ovf),
  .msg_valid  (msg_valid),
  .msg_sev    (msg_sev),
  .dev_status (dev_status),
  .cor_status (cor_status),
  .clr_cor    (clr_cor)
);

// File: tb/sim_err_signal_unit.sv
`timescale 1ns/1ps
module sim_err_signal_unit;
  localparam logic [31:0] COR_SUP  = 32'h0000F1C1;
  localparam logic [31:0] UNC_SUP  = 32'h03FFF030;
  localparam logic [31:0] DEF_FAT  = 32'h00462030;
  localparam logic [31:0] UR_BIT   = 32'h00100000;
  localparam logic [31:0] ADV_BIT  = 32'h00002000;
  localparam logic [31:0] HLO_BIT  = 32'h00008000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        evt_valid = 0, evt_is_cor = 0, evt_adv_ok = 0;
  logic [31:0] evt_status = 0;
  logic [15:0] evt_src = 0;
  logic [31:0] cfg_cor_mask = 0, cfg_unc_mask = 0, cfg_unc_sev = DEF_FAT;
  logic        cfg_sev_use_reg = 1, cfg_serr_en = 1, cfg_cor_rep_en = 1;
  logic        cfg_nf_rep_en = 1, cfg_fat_rep_en = 1, cfg_ur_rep_en = 1;
  logic [31:0] clr_cor = 0, clr_unc = 0;
  logic [3:0]  clr_dev = 0;
  logic        force_ovf = 0;

  logic        evt_ready, log_req, msg_valid, log_ovf;
  logic [31:0] log_status, cor_status, unc_status;
  logic [15:0] log_src, msg_src;
  logic [1:0]  msg_sev;
  logic [3:0]  dev_status;

  assign log_ovf = log_req & force_ovf;

  err_signal_unit u0 (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_status(evt_status), .evt_is_cor(evt_is_cor), .evt_adv_ok(evt_adv_ok),
    .evt_src(evt_src), .cfg_cor_mask(cfg_cor_mask), .cfg_unc_mask(cfg_unc_mask),
    .cfg_unc_sev(cfg_unc_sev), .cfg_sev_use_reg(cfg_sev_use_reg),
    .cfg_serr_en(cfg_serr_en), .cfg_cor_rep_en(cfg_cor_rep_en),
    .cfg_nf_rep_en(cfg_nf_rep_en), .cfg_fat_rep_en(cfg_fat_rep_en),
    .cfg_ur_rep_en(cfg_ur_rep_en), .clr_cor(clr_cor), .clr_unc(clr_unc),
    .clr_dev(clr_dev), .log_req(log_req), .log_status(log_status),
    .log_src(log_src), .log_ovf(log_ovf), .msg_valid(msg_valid),
    .msg_sev(msg_sev), .msg_src(msg_src), .dev_status(dev_status),
    .cor_status(cor_status), .unc_status(unc_status)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_log_req = 0, m_msg = 0, m_pend = 0;
  logic [1:0]  m_sev = 0;
  logic [15:0] m_msg_src = 0, m_log_src = 0, m_pend_src = 0;
  logic [31:0] m_log_st = 0, m_cor = 0, m_unc = 0;
  logic [3:0]  m_dev = 0;
  bit          started = 0;

  always @(posedge clk) begin
    logic        have, e_cor, e_adv, rdy, fat, ur, nx_pend;
    logic [31:0] e_st, sv, s_cor, s_unc;
    logic [15:0] e_src, nx_psrc;
    logic [3:0]  s_dev;
    logic        n_msg, n_log;
    logic [1:0]  n_sev;
    started <= 1;
    if (rst) begin
      m_log_req = 0; m_msg = 0; m_pend = 0; m_sev = 0; m_msg_src = 0;
      m_log_src = 0; m_pend_src = 0; m_log_st = 0; m_cor = 0; m_unc = 0; m_dev = 0;
    end else begin
      rdy = !m_log_req && !m_pend;
      have = 0; e_cor = 0; e_adv = 0; e_st = 0; e_src = 0;
      if (m_pend) begin
        have = 1; e_cor = 1; e_st = HLO_BIT; e_src = m_pend_src;
      end else if (evt_valid && rdy) begin
        have = 1; e_cor = evt_is_cor; e_adv = evt_adv_ok; e_st = evt_status; e_src = evt_src;
      end
      nx_pend = m_log_req && force_ovf;
      nx_psrc = nx_pend ? m_log_src : m_pend_src;
      s_cor = 0; s_unc = 0; s_dev = 0; n_msg = 0; n_log = 0; n_sev = 0;
      if (have) begin
        sv = e_cor ? (e_st & COR_SUP) : (e_st & UNC_SUP);
        if ($countones(sv) == 1) begin
          ur  = !e_cor && (sv == UR_BIT);
          fat = cfg_sev_use_reg ? ((sv & cfg_unc_sev) != 0) : ((sv & DEF_FAT) != 0);
          if (ur) s_dev[3] = 1;
          if (e_cor) begin
            s_dev[0] = 1; s_cor = sv;
            if ((sv & cfg_cor_mask) == 0 && cfg_cor_rep_en) begin n_msg = 1; n_sev = 1; end
          end else if (!fat && e_adv) begin
            s_dev[0] = 1; s_cor = ADV_BIT; s_unc = sv;
            n_log = ((sv & cfg_unc_mask) == 0);
            if ((ADV_BIT & cfg_cor_mask) == 0 && !(ur && !cfg_ur_rep_en) && cfg_cor_rep_en) begin
              n_msg = 1; n_sev = 1;
            end
          end else begin
            if (fat) s_dev[2] = 1; else s_dev[1] = 1;
            s_unc = sv;
            if ((sv & cfg_unc_mask) == 0) begin
              n_log = 1;
              if (!(ur && !cfg_ur_rep_en && !cfg_serr_en)) begin
                if (fat && (cfg_serr_en || cfg_fat_rep_en)) begin n_msg = 1; n_sev = 3; end
                if (!fat && (cfg_serr_en || cfg_nf_rep_en)) begin n_msg = 1; n_sev = 2; end
              end
            end
          end
        end
      end
      m_cor = (m_cor & ~clr_cor) | s_cor;
      m_unc = (m_unc & ~clr_unc) | s_unc;
      m_dev = (m_dev & ~clr_dev) | s_dev;
      m_msg = n_msg; m_sev = n_sev;
      if (n_msg) m_msg_src = e_src;
      if (n_log) begin m_log_st = sv; m_log_src = e_src; end
      m_log_req = n_log;
      m_pend = nx_pend; m_pend_src = nx_psrc;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R11 model evt_ready", evt_ready, !m_log_req && !m_pend);
      chk("R10 model msg_valid", msg_valid, m_msg);
      chk("R10 model msg_sev", msg_sev, m_sev);
      if (m_msg) chk("R10 model msg_src", msg_src, m_msg_src);
      chk("R5 model log_req", log_req, m_log_req);
      if (m_log_req) begin
        chk("R5 model log_status", log_status, m_log_st);
        chk("R5 model log_src", log_src, m_log_src);
      end
      chk("R3 model cor_status", cor_status, m_cor);
      chk("R4 model unc_status", unc_status, m_unc);
      chk("R5 model dev_status", dev_status, m_dev);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic send(input logic cor, input logic adv, input logic [31:0] st, input logic [15:0] src);
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1; evt_is_cor = cor; evt_adv_ok = adv; evt_status = st; evt_src = src;
    @(negedge clk);
    evt_valid = 0; evt_status = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_cor = '1; clr_unc = '1; clr_dev = '1;
    @(negedge clk);
    clr_cor = 0; clr_unc = 0; clr_dev = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset ready", evt_ready, 1);
    chk("R11 reset cor_status", cor_status, 0);
    chk("R11 reset unc_status", unc_status, 0);
    chk("R11 reset dev_status", dev_status, 0);

    send(0, 0, 32'h3, 16'h1);
    chk("R1 unsupported-only msg", msg_valid, 0);
    chk("R1 unsupported-only unc", unc_status, 0);
    send(1, 0, 32'h41, 16'h1);
    chk("R1 two-bit cor msg", msg_valid, 0);
    chk("R1 two-bit cor status", cor_status, 0);
    send(0, 0, 32'h0010_0003, 16'h0A0A);
    chk("R1 filtered UR msg_sev", msg_sev, 2);
    chk("R1 filtered UR unc", unc_status, UR_BIT);
    chk("R7 UR dev bits", dev_status, 4'hA);
    chk("R5 UR log_status", log_status, UR_BIT);

    send(1, 0, 32'h40, 16'h1234);
    chk("R3 cor msg_valid", msg_valid, 1);
    chk("R3 cor msg_sev", msg_sev, 1);
    chk("R10 cor msg_src", msg_src, 16'h1234);
    chk("R3 cor status", cor_status, 32'h40);
    chk("R3 cor dev", dev_status, 4'hB);
    cfg_cor_mask = 32'h80;
    send(1, 0, 32'h80, 16'h1);
    chk("R3 masked cor msg", msg_valid, 0);
    chk("R3 masked cor status", cor_status, 32'hC0);
    cfg_cor_mask = 0; cfg_cor_rep_en = 0;
    send(1, 0, 32'h1, 16'h1);
    chk("R3 cor enable off", msg_valid, 0);
    cfg_cor_rep_en = 1;

    clear_all();
    chk("R12 clear cor", cor_status, 0);
    chk("R12 clear unc", unc_status, 0);
    chk("R12 clear dev", dev_status, 0);

    send(0, 0, 32'h0004_0000, 16'h2);
    chk("R5 fatal msg_sev", msg_sev, 3);
    chk("R5 fatal log_req", log_req, 1);
    chk("R5 fatal log_status", log_status, 32'h0004_0000);
    chk("R5 fatal dev", dev_status, 4'h4);

    cfg_unc_sev = DEF_FAT | 32'h1000;
    send(0, 0, 32'h1000, 16'h3);
    chk("R2 sev reg makes fatal", msg_sev, 3);
    cfg_sev_use_reg = 0; cfg_unc_sev = 0;
    send(0, 0, 32'h1000, 16'h3);
    chk("R2 default nonfatal", msg_sev, 2);
    send(0, 0, 32'h10, 16'h3);
    chk("R2 default fatal", msg_sev, 3);
    cfg_sev_use_reg = 1; cfg_unc_sev = DEF_FAT;

    clear_all();
    cfg_unc_mask = 32'h0008_0000;
    send(0, 0, 32'h0008_0000, 16'h4);
    chk("R4 masked msg", msg_valid, 0);
    chk("R4 masked log", log_req, 0);
    chk("R4 masked unc", unc_status, 32'h0008_0000);
    chk("R4 masked dev", dev_status, 4'h2);
    cfg_unc_mask = 0;

    clear_all();
    send(0, 1, 32'h8000, 16'h0055);
    chk("R6 adv msg_sev", msg_sev, 1);
    chk("R6 adv src", msg_src, 16'h0055);
    chk("R6 adv cor", cor_status, ADV_BIT);
    chk("R6 adv unc", unc_status, 32'h8000);
    chk("R6 adv log", log_req, 1);
    chk("R6 adv dev", dev_status, 4'h1);
    cfg_unc_mask = 32'h8000;
    send(0, 1, 32'h8000, 16'h0055);
    chk("R6 adv unc-masked log", log_req, 0);
    chk("R6 adv unc-masked msg", msg_sev, 1);
    cfg_unc_mask = 0; cfg_cor_mask = ADV_BIT;
    send(0, 1, 32'h8000, 16'h0055);
    chk("R6 adv cor-masked msg", msg_valid, 0);
    cfg_cor_mask = 0;
    send(0, 1, 32'h0004_0000, 16'h0056);
    chk("R6 fatal ignores adv", msg_sev, 3);

    clear_all();
    cfg_ur_rep_en = 0;
    send(0, 0, UR_BIT, 16'h7);
    chk("R7 UR with serr", msg_sev, 2);
    chk("R7 UR dev", dev_status, 4'hA);
    cfg_serr_en = 0;
    send(0, 0, UR_BIT, 16'h7);
    chk("R7 UR suppressed", msg_valid, 0);
    send(0, 1, UR_BIT, 16'h7);
    chk("R7 UR adv suppressed", msg_valid, 0);
    cfg_ur_rep_en = 1;
    send(0, 1, UR_BIT, 16'h7);
    chk("R7 UR adv sent", msg_sev, 1);

    cfg_nf_rep_en = 0;
    send(0, 0, 32'h1000, 16'h8);
    chk("R8 nonfatal blocked", msg_valid, 0);
    cfg_nf_rep_en = 1;
    send(0, 0, 32'h1000, 16'h8);
    chk("R8 nonfatal enable", msg_sev, 2);
    cfg_fat_rep_en = 0;
    send(0, 0, 32'h0004_0000, 16'h8);
    chk("R8 fatal blocked", msg_valid, 0);
    cfg_serr_en = 1;
    send(0, 0, 32'h0004_0000, 16'h8);
    chk("R8 fatal via serr", msg_sev, 3);
    cfg_fat_rep_en = 1;

    clear_all();
    force_ovf = 1;
    send(0, 0, 32'h0001_0000, 16'h0BEE);
    chk("R9 ovf first msg", msg_sev, 2);
    chk("R11 busy while logging", evt_ready, 0);
    @(negedge clk);
    force_ovf = 0;
    chk("R11 pending hold", evt_ready, 0);
    chk("R9 no msg yet", msg_valid, 0);
    @(negedge clk);
    chk("R9 follow-up msg", msg_sev, 1);
    chk("R9 follow-up src", msg_src, 16'h0BEE);
    chk("R9 follow-up status", cor_status, HLO_BIT);
    chk("R11 ready again", evt_ready, 1);

    @(negedge clk);
    evt_valid = 1; evt_is_cor = 1; evt_adv_ok = 0; evt_status = 32'h80; clr_cor = '1;
    @(negedge clk);
    evt_valid = 0; clr_cor = 0;
    chk("R12 set beats clear", cor_status, 32'h80);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R11 run did not finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule